// File: doc/BRIEF.md
# Multicycle Immediate-Operand CPU Core

A small processor core that runs 32-bit instructions out of a 512-byte byte-addressed memory. Every instruction takes two clock cycles. In the fetch cycle the core presents the instruction pointer on a synchronous read port. In the execute cycle the returned word is decoded and applied. Each arithmetic instruction combines one 64-bit register, chosen from sixteen, with a 16-bit zero-extended immediate. A branch instruction loads the instruction pointer from a register. The core also holds a state register with a supervisor flag, room for a carry flag and two sticky fault flags, plus a branch link and an interrupt link register. Both link registers are held at their reset value.

The core starts at address 0 after reset and runs until one of two things happens: it executes a halt instruction, or its instruction pointer leaves the memory. A debug select input reads any architectural register combinationally, so a host or testbench can inspect the state once `halted` is high.

Top module: `cpu_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released: the instruction pointer, all sixteen X registers and both link registers read 0; the state register reads 0x2 (bit 1 is the supervisor flag); `halted` is 0; and a read of address 0 is requested.
- R2: An instruction word carries the opcode in bits [7:0], the destination index in bits [15:8] and the immediate in bits [31:16], with the immediate's low byte at byte offset 2 (little-endian). The read data arrives the cycle after `mem_re`, and every instruction takes one fetch cycle followed by one execute cycle.
- R3: ADD (0x01), SUB (0x02), MUL (0x03) and DIV (0x04) replace X[rd] with X[rd] combined with the zero-extended immediate. Results wrap modulo 2^64, and DIV is unsigned integer division.
- R4: INC (0x05) adds 1 to X[rd], DEC (0x06) subtracts 1 from X[rd], both wrapping, and MOV (0x13) loads the zero-extended immediate into X[rd].
- R5: Opcodes 0x00, 0x07, 0x08, 0x09, 0x10, 0x11 and 0x12, and any opcode value not listed here, change no register and raise no flag, whatever their destination field holds.
- R6: Every instruction other than HLT, and other than a branch, leaves the instruction pointer 4 higher.
- R7: HLT (0x14) stops the core. The instruction pointer keeps the HLT's address, `halted` stays 1 until reset, and no further reads are requested.
- R8: Execution stops with `halted` = 1 once the instruction pointer is at or beyond 512. This holds both after a step of 4 and after a branch, and the out-of-range value stays in the pointer.
- R9: BR (0x15) with a nonzero target T = X[rd] sets the instruction pointer to T + 4 when T is below 512.
- R10: BR with a zero target first returns all X registers, both link registers and the state register to their R1 values, then continues at address 4.
- R11: An ALU, MOV or BR instruction whose destination index is 16 or more changes no register, sets sticky state bit 3, and advances by 4.
- R12: DIV with a zero immediate leaves X[rd] unchanged and sets sticky state bit 4.
- R13: `dbg_sel` values 0 to 15 return X0 to X15, 16 returns the instruction pointer, 17 the state register, 18 the branch link register, 19 the interrupt link register, and any other value returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_re | output | 1 | Instruction read request |
| mem_addr | output | 9 | Byte address of the requested word |
| mem_rdata | input | 32 | Word read, valid the cycle after the request |
| halted | output | 1 | Core has stopped |
| dbg_sel | input | 5 | Debug register select |
| dbg_data | output | 64 | Selected register value |

## Verification
Two functions share one execute cycle: the full architectural reset caused by a branch to address zero, and the normal advance of the instruction pointer by 4. The bench provokes this with a program that decrements a register to zero and branches through it. After the reset the code runs again from address 4 with cleared registers. On the second pass the same decrement wraps the register to all ones, and the branch then leaves memory. The result is judged through the debug port. A counter register incremented on both passes must read 2, not 4, which shows the wipe took effect and that address 0 was skipped. The state register must be back at its reset value, and the instruction pointer must hold the wrapped target.

// File: rtl/cpu_core_pkg.sv
package cpu_core_pkg;
    parameter int XLEN   = 64;
    parameter int NREG   = 16;
    parameter int IMM_W  = 16;
    parameter int INSN_W = 32;
    localparam int IDX_W = $clog2(NREG);

    typedef logic [XLEN-1:0] word_t;

    // opcode byte values
    localparam logic [7:0] OP_ADD = 8'h01;
    localparam logic [7:0] OP_SUB = 8'h02;
    localparam logic [7:0] OP_MUL = 8'h03;
    localparam logic [7:0] OP_DIV = 8'h04;
    localparam logic [7:0] OP_INC = 8'h05;
    localparam logic [7:0] OP_DEC = 8'h06;
    localparam logic [7:0] OP_MOV = 8'h13;
    localparam logic [7:0] OP_HLT = 8'h14;
    localparam logic [7:0] OP_BR  = 8'h15;

    // state register bit positions
    localparam int SR_SUPV   = 1;
    localparam int SR_CARRY  = 2;
    localparam int SR_BADIDX = 3;
    localparam int SR_DIVZ   = 4;
    localparam word_t SR_RESET = word_t'(1) << SR_SUPV;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_HALT  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e               phase;
        word_t                ip;
        word_t                sr;
        word_t                blr;
        word_t                ilr;
        word_t [NREG-1:0]     x;
    } core_state_t;
endpackage

// File: rtl/cpu_core_decode.sv
module cpu_core_decode
    import cpu_core_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output logic [7:0]        opcode,
    output logic [7:0]        rd_idx,
    output logic [IMM_W-1:0]  imm,
    output logic              rd_ok,
    output logic              is_alu,
    output logic              is_br,
    output logic              is_hlt
);
    always_comb begin
        opcode = insn[7:0];
        rd_idx = insn[15:8];
        imm    = insn[16 +: IMM_W];
        rd_ok  = (rd_idx < 8'(NREG));
        is_br  = (opcode == OP_BR);
        is_hlt = (opcode == OP_HLT);
        unique case (opcode)
            OP_ADD, OP_SUB, OP_MUL, OP_DIV,
            OP_INC, OP_DEC, OP_MOV: is_alu = 1'b1;
            default:                is_alu = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpu_core_alu.sv
module cpu_core_alu
    import cpu_core_pkg::*;
(
    input  logic [7:0]       opcode,
    input  word_t            src,
    input  logic [IMM_W-1:0] imm,
    output word_t            result,
    output logic             div_fault
);
    word_t imm_ext;

    always_comb begin
        imm_ext   = word_t'(imm);
        div_fault = (opcode == OP_DIV) && (imm == '0);
        unique case (opcode)
            OP_ADD:  result = src + imm_ext;
            OP_SUB:  result = src - imm_ext;
            OP_MUL:  result = src * imm_ext;
            OP_DIV:  result = div_fault ? src : (src / imm_ext);
            OP_INC:  result = src + word_t'(1);
            OP_DEC:  result = src - word_t'(1);
            OP_MOV:  result = imm_ext;
            default: result = src;
        endcase
    end
endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_core_pkg::*;
#(
    parameter int MEM_BYTES = 512
) (
    input  logic                         clk,
    input  logic                         rst_n,
    output logic                         mem_re,
    output logic [$clog2(MEM_BYTES)-1:0] mem_addr,
    input  logic [INSN_W-1:0]            mem_rdata,
    output logic                         halted,
    input  logic [$clog2(NREG+4)-1:0]    dbg_sel,
    output logic [XLEN-1:0]              dbg_data
);
    localparam int    ADDR_W      = $clog2(MEM_BYTES);
    localparam int    SEL_W       = $clog2(NREG + 4);
    localparam word_t MEM_LIMIT   = word_t'(MEM_BYTES);
    localparam word_t INSN_BYTES  = word_t'(INSN_W / 8);
    localparam core_state_t RESET_STATE = '{
        phase: ST_FETCH, ip: '0, sr: SR_RESET, blr: '0, ilr: '0, x: '0};

    core_state_t cur_q, nxt_d;

    logic [7:0]       opcode;
    logic [7:0]       rd_idx;
    logic [IMM_W-1:0] imm;
    logic             rd_ok, is_alu, is_br, is_hlt, div_fault;
    word_t            src, alu_res, ip_mid;
    logic             br_zero;

    cpu_core_decode u_dec (
        .insn   (mem_rdata),
        .opcode (opcode),
        .rd_idx (rd_idx),
        .imm    (imm),
        .rd_ok  (rd_ok),
        .is_alu (is_alu),
        .is_br  (is_br),
        .is_hlt (is_hlt)
    );

    assign src = cur_q.x[rd_idx[IDX_W-1:0]];

    cpu_core_alu u_alu (
        .opcode    (opcode),
        .src       (src),
        .imm       (imm),
        .result    (alu_res),
        .div_fault (div_fault)
    );

    always_comb begin
        nxt_d   = cur_q;
        mem_re  = 1'b0;
        br_zero = 1'b0;
        ip_mid  = cur_q.ip;
        unique case (cur_q.phase)
            ST_FETCH: begin
                if (cur_q.ip >= MEM_LIMIT) begin
                    nxt_d.phase = ST_HALT;
                end else begin
                    mem_re      = 1'b1;
                    nxt_d.phase = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (is_hlt) begin
                    nxt_d.phase = ST_HALT;
                end else begin
                    if ((is_alu || is_br) && !rd_ok) begin
                        nxt_d.sr[SR_BADIDX] = 1'b1;
                    end else if (is_br) begin
                        ip_mid = src;
                        if (src == '0) begin
                            br_zero   = 1'b1;
                            nxt_d.x   = '0;
                            nxt_d.blr = '0;
                            nxt_d.ilr = '0;
                            nxt_d.sr  = SR_RESET;
                        end
                    end else if (is_alu) begin
                        if (div_fault) nxt_d.sr[SR_DIVZ] = 1'b1;
                        else           nxt_d.x[rd_idx[IDX_W-1:0]] = alu_res;
                    end
                    if (ip_mid >= MEM_LIMIT) begin
                        nxt_d.ip    = ip_mid;
                        nxt_d.phase = ST_HALT;
                    end else begin
                        nxt_d.ip    = ip_mid + INSN_BYTES;
                        nxt_d.phase = ST_FETCH;
                    end
                end
            end
            default: nxt_d.phase = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= RESET_STATE;
        else        cur_q <= nxt_d;
    end

    assign mem_addr = cur_q.ip[ADDR_W-1:0];
    assign halted   = (cur_q.phase == ST_HALT);

    always_comb begin
        if (dbg_sel < SEL_W'(NREG)) begin
            dbg_data = cur_q.x[dbg_sel[IDX_W-1:0]];
        end else begin
            unique case (dbg_sel - SEL_W'(NREG))
                SEL_W'(0): dbg_data = cur_q.ip;
                SEL_W'(1): dbg_data = cur_q.sr;
                SEL_W'(2): dbg_data = cur_q.blr;
                SEL_W'(3): dbg_data = cur_q.ilr;
                default:   dbg_data = '0;
            endcase
        end
    end

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_re));

    // R2
    exec_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == ST_EXEC) |-> $past(mem_re));

    // R6
    ip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_q.phase) == ST_EXEC && cur_q.phase == ST_FETCH && !$past(is_br))
        |-> cur_q.ip == $past(cur_q.ip) + INSN_BYTES);

    // R10
    zero_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_zero |=> (cur_q.ip == INSN_BYTES && cur_q.sr == SR_RESET && cur_q.x == '0));

    // R11
    badidx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_q.sr[SR_BADIDX]) |-> $past(br_zero));
endmodule

// File: tb/cpu_core_bench.sv
`timescale 1ns/1ps
module cpu_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_re;
    logic [8:0]  mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        halted;
    logic [4:0]  dbg_sel = '0;
    logic [63:0] dbg_data;

    logic [7:0]  mem [512];
    int          nvec = 0;
    int          nfail = 0;

    typedef struct {
        logic [4:0]  sel;
        logic [63:0] val;
        string       tag;
    } exp_t;
    exp_t q[$];

    localparam logic [4:0] S_IP = 5'd16, S_SR = 5'd17, S_BLR = 5'd18, S_ILR = 5'd19;
    localparam logic [63:0] ONES = '1;

    always #4 clk = ~clk;

    cpu_core u_cpu_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .halted    (halted),
        .dbg_sel   (dbg_sel),
        .dbg_data  (dbg_data)
    );

    // synchronous byte memory, little-endian word assembly
    always @(posedge clk) begin
        if (mem_re)
            mem_rdata <= {mem[(mem_addr + 3) % 512], mem[(mem_addr + 2) % 512],
                          mem[(mem_addr + 1) % 512], mem[mem_addr]};
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: pops expected register values and compares via the debug port
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                dbg_sel = e.sel;
                #1;
                check(e.tag, dbg_data, e.val);
            end
        end
    end

    task automatic expect_reg(input logic [4:0] sel, input logic [63:0] val, input string tag);
        exp_t e;
        e.sel = sel; e.val = val; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    endtask

    task automatic put(input int a, input logic [7:0] op, input logic [7:0] rd, input logic [15:0] imm);
        mem[a]     = op;
        mem[a + 1] = rd;
        mem[a + 2] = imm[7:0];
        mem[a + 3] = imm[15:8];
    endtask

    // reset, release, count clock edges until halted
    task automatic run(output int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cycles = 0;
        while (cycles < 5000) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
            if (halted) break;
        end
        if (!halted) check("R7 run did not halt", 64'(halted), 64'd1);
    endtask

    initial begin
        int cyc;
        clear_mem();

        // P1: arithmetic, immediate layout, no-op opcodes, halt
        put(0,  8'h13, 8'd1, 16'd100);
        put(4,  8'h01, 8'd1, 16'hFFFF);
        put(8,  8'h13, 8'd2, 16'd5);
        put(12, 8'h02, 8'd2, 16'd7);
        put(16, 8'h13, 8'd3, 16'h1000);
        put(20, 8'h03, 8'd3, 16'h1000);
        put(24, 8'h13, 8'd4, 16'd1000);
        put(28, 8'h04, 8'd4, 16'd7);
        put(32, 8'h05, 8'd5, 16'd0);
        put(36, 8'h06, 8'd6, 16'd0);
        put(40, 8'h07, 8'd1, 16'hFFFF);
        put(44, 8'h10, 8'hFF, 16'h0001);
        put(48, 8'h0A, 8'd2, 16'd3);
        put(52, 8'h14, 8'd0, 16'd0);
        put(56, 8'h13, 8'd7, 16'd9);
        run(cyc);
        check("R2 two cycles per instruction", 64'(cyc), 64'd28);
        check("R7 halted after HLT", 64'(halted), 64'd1);
        check("R7 no read while halted", 64'(mem_re), 64'd0);
        expect_reg(5'd1, 64'd65635, "R3 ADD zero-extended immediate");
        expect_reg(5'd2, 64'hFFFF_FFFF_FFFF_FFFE, "R3 SUB wraps");
        expect_reg(5'd3, 64'h100_0000, "R3 MUL");
        expect_reg(5'd4, 64'd142, "R3 DIV unsigned");
        expect_reg(5'd5, 64'd1, "R4 INC");
        expect_reg(5'd6, ONES, "R4 DEC wraps");
        expect_reg(5'd7, 64'd0, "R7 nothing after HLT");
        expect_reg(S_IP, 64'd52, "R7 ip stays at HLT");
        expect_reg(S_SR, 64'h2, "R5 no-op opcodes raise no flag");
        expect_reg(5'd25, 64'd0, "R13 unmapped select reads zero");
        drain();

        // P2: invalid index and divide by zero
        clear_mem();
        put(0,  8'h13, 8'd0, 16'd9);
        put(4,  8'h13, 8'd20, 16'd7);
        put(8,  8'h04, 8'd0, 16'd0);
        put(12, 8'h15, 8'd16, 16'd0);
        put(16, 8'h14, 8'd0, 16'd0);
        run(cyc);
        expect_reg(5'd0, 64'd9, "R12 DIV by zero keeps register");
        expect_reg(5'd4, 64'd0, "R11 invalid index writes nothing");
        expect_reg(S_SR, 64'h1A, "R11 R12 sticky flags");
        expect_reg(S_IP, 64'd16, "R11 invalid BR advances");
        drain();

        // P3: branch to nonzero target
        clear_mem();
        put(0,  8'h13, 8'd7, 16'd64);
        put(4,  8'h15, 8'd7, 16'd0);
        put(8,  8'h13, 8'd8, 16'h0BAD);
        put(64, 8'h13, 8'd8, 16'h0BAD);
        put(68, 8'h13, 8'd9, 16'd3);
        put(72, 8'h14, 8'd0, 16'd0);
        run(cyc);
        expect_reg(5'd8, 64'd0, "R9 branch skips target and fall-through");
        expect_reg(5'd9, 64'd3, "R9 continues at target plus 4");
        expect_reg(S_IP, 64'd72, "R9 ip");
        expect_reg(5'd7, 64'd64, "R9 branch source intact");
        drain();

        // P4: branch to zero resets state in the same cycle as the advance
        clear_mem();
        put(0,  8'h13, 8'd1, 16'd1);
        put(4,  8'h05, 8'd3, 16'd0);
        put(8,  8'h05, 8'd3, 16'd0);
        put(12, 8'h06, 8'd1, 16'd0);
        put(16, 8'h15, 8'd1, 16'd0);
        run(cyc);
        expect_reg(5'd3, 64'd2, "R10 registers wiped and restart at 4");
        expect_reg(5'd1, ONES, "R10 second pass wraps");
        expect_reg(S_IP, ONES, "R8 halt on out-of-range branch");
        expect_reg(S_SR, 64'h2, "R10 state register restored");
        drain();
        check("R8 halted after branch past memory", 64'(halted), 64'd1);

        // R1: reset state observed while reset is held
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 halted cleared", 64'(halted), 64'd0);
        check("R1 read requested", 64'(mem_re), 64'd1);
        check("R1 read address zero", 64'(mem_addr), 64'd0);
        expect_reg(S_IP, 64'd0, "R1 ip");
        expect_reg(5'd3, 64'd0, "R1 x3");
        expect_reg(5'd1, 64'd0, "R1 x1");
        expect_reg(S_SR, 64'h2, "R1 state register");
        expect_reg(S_BLR, 64'd0, "R1 branch link");
        expect_reg(S_ILR, 64'd0, "R1 interrupt link");
        drain();

        // P5: run off the end of memory through no-ops
        clear_mem();
        put(508, 8'h13, 8'd10, 16'hABCD);
        run(cyc);
        check("R8 halts at memory end", 64'(halted), 64'd1);
        check("R6 R8 cycle count", 64'(cyc), 64'd257);
        expect_reg(S_IP, 64'd512, "R6 R8 ip at end");
        expect_reg(5'd10, 64'hABCD, "R2 R4 last word executed");
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule